// File: doc/BRIEF.md
# Ordered Decay Elapsed-Time Estimator

This block runs at boot and estimates how long a volatile memory went without power. A prior profiling step measured, for each tracked cell whose natural power-up value is 0, the moment at which the cell loses a stored 1 and falls back to 0. The cells were sorted by that moment and split into consecutive groups of equal size; the resulting list of cell addresses sits in a small non-volatile table that the block reads through an index/data port. Because decay follows that order, all groups before some boundary have lost their ones and all groups after it still hold them. The block finds that boundary by binary search and reports its group index as the elapsed-time estimate.

A single group is judged by a majority vote over its cells, so a few cells that are metastable near their own transition time do not move the result. Two further operations take a fixed number of cycles whatever the memory holds. The init operation writes a 1 into every tracked cell before the next power-down. The full-decay check reads only the last group in the order, whose cells are the last to revert.

Top module: `decay_clock_est`

## Requirements
- R1: After reset, busy, done, cell_set and full_decayed are low and est_groups is 0.
- R2: An init operation drives cell_set with cell_addr equal to the table cell of every order position 0 to NGROUPS*GSIZE-1, one per cycle. It makes exactly NGROUPS*GSIZE writes, touches no cell outside the table, and raises done on the rising edge after the last write. The operation therefore takes NGROUPS*GSIZE+1 edges, counting the edge that samples the start.
- R3: Group g covers order positions g*GSIZE to g*GSIZE+GSIZE-1. The group is judged decayed when more than half of its cells read 0. A group in which exactly half of its cells read 0 is judged still holding.
- R4: For memory contents that are ordered (all decayed groups come before all holding groups), est_groups after an estimate equals the index of the first holding group. If every group is decayed, it equals NGROUPS.
- R5: An estimate reads GSIZE cells per probe and makes at most ceil(log2(NGROUPS+1)) probes. The operation therefore takes 1+GSIZE*P edges for some P between 1 and that bound.
- R6: A full-decay check reads only order positions (NGROUPS-1)*GSIZE upward and takes exactly GSIZE+1 edges. full_decayed then equals the R3 verdict for the last group.
- R7: When more than one start input is high in an idle cycle, init takes priority over the full check, and the full check takes priority over the estimate.
- R8: Start inputs that arrive while busy is high are ignored. They cause no write and do not change the result of the operation in flight.
- R9: done is high for one cycle only. est_groups changes only when an estimate completes, and full_decayed changes only when a full check completes.
- R10: cell_set is high only while an operation is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_init | input | 1 | Request to write 1 into all tracked cells |
| start_full | input | 1 | Request for the constant-time full-decay check |
| start_est | input | 1 | Request for the binary-search estimate |
| tbl_idx | output | $clog2(NGROUPS*GSIZE) | Order position presented to the order table |
| tbl_cell | input | CELL_AW | Cell address stored at tbl_idx (combinational read) |
| cell_addr | output | CELL_AW | Address of the tracked-memory cell being accessed |
| cell_set | output | 1 | Write a 1 to cell_addr on this edge |
| cell_rdata | input | 1 | Current value of the cell at cell_addr (combinational read) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| full_decayed | output | 1 | Verdict of the last full-decay check |
| est_groups | output | $clog2(NGROUPS+1) | Result of the last estimate, 0 to NGROUPS |

## Verification
The bench targets the vote threshold with a group holding exactly two zeros out of four. A design that rounded the tie toward decay would report the boundary one group too late. It also covers both search extremes, with nothing decayed and everything decayed. An off-by-one in the lo/hi update would either stall below NGROUPS or read past the last group. Start pulses are injected mid-search and issued together in one cycle. A controller that re-accepted starts while busy would rewrite the memory during an estimate, and one with the wrong priority would run the wrong operation. The full check is watched through tbl_idx and its exact latency, because a version that scanned more than the last group would either run longer or present an earlier order position.

// File: rtl/decay_est_pkg.sv
package decay_est_pkg;

  // A group is decayed only on a strict majority of zeros; a tie holds.
  function automatic bit group_is_decayed(input int zeros, input int gsize);
    return (zeros * 2) > gsize;
  endfunction

  // Midpoint of the open search interval [lo, hi).
  function automatic int search_mid(input int lo, input int hi);
    return (lo + hi) / 2;
  endfunction

  // Order position of a member inside a group.
  function automatic int order_pos(input int grp, input int member, input int gsize);
    return grp * gsize + member;
  endfunction

  // Upper bound on probes for a search over n groups: ceil(log2(n+1)).
  function automatic int probe_bound(input int n);
    int b;
    b = 0;
    while ((1 << b) < (n + 1)) b++;
    return b;
  endfunction

endpackage

// File: rtl/decay_vote_acc.sv
module decay_vote_acc #(
  parameter int GSIZE = 4,
  localparam int CNT_W = $clog2(GSIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             sample_last,
  input  logic             cell_zero,
  output logic [CNT_W-1:0] zeros_so_far,
  output logic             verdict_decayed
);
  import decay_est_pkg::*;

  logic [CNT_W-1:0] zero_cnt;
  logic [CNT_W-1:0] zero_total;

  assign zero_total      = zero_cnt + CNT_W'(cell_zero);
  assign zeros_so_far    = zero_cnt;
  assign verdict_decayed = group_is_decayed(int'(zero_total), GSIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_cnt <= '0;
    end else if (sample_en) begin
      if (sample_last) zero_cnt <= '0;
      else             zero_cnt <= zero_total;
    end
  end

  // R3: the accumulated zero count never exceeds the group size
  assert_vote_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zero_cnt) < GSIZE);

  // R3: a fresh group always starts counting from zero
  assert_vote_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && sample_last) |=> (zero_cnt == '0));

endmodule

// File: rtl/decay_bsearch.sv
module decay_bsearch #(
  parameter int NGROUPS = 16,
  localparam int RES_W = $clog2(NGROUPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             step_decayed,
  output logic [RES_W-1:0] mid,
  output logic             fin_next,
  output logic [RES_W-1:0] res_next
);
  import decay_est_pkg::*;

  logic [RES_W-1:0] lo, hi;
  logic [RES_W-1:0] lo_n, hi_n;

  assign mid      = RES_W'(search_mid(int'(lo), int'(hi)));
  assign lo_n     = step_decayed ? (mid + RES_W'(1)) : lo;
  assign hi_n     = step_decayed ? hi : mid;
  assign fin_next = (lo_n == hi_n);
  assign res_next = lo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (load) begin
      lo <= '0;
      hi <= RES_W'(NGROUPS);
    end else if (step) begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  // R4: the search window never inverts
  assert_window_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo <= hi);

  // R4: a probe is only taken inside a non-empty window
  assert_probe_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (lo < hi) && (mid < hi));

endmodule

// File: rtl/decay_clock_est.sv
module decay_clock_est #(
  parameter int NGROUPS = 16,
  parameter int GSIZE   = 4,
  parameter int CELL_AW = 8,
  localparam int LEN   = NGROUPS * GSIZE,
  localparam int IDX_W = $clog2(LEN),
  localparam int RES_W = $clog2(NGROUPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_init,
  input  logic               start_full,
  input  logic               start_est,
  output logic [IDX_W-1:0]   tbl_idx,
  input  logic [CELL_AW-1:0] tbl_cell,
  output logic [CELL_AW-1:0] cell_addr,
  output logic               cell_set,
  input  logic               cell_rdata,
  output logic               busy,
  output logic               done,
  output logic               full_decayed,
  output logic [RES_W-1:0]   est_groups
);
  import decay_est_pkg::*;

  localparam int MEM_W     = (GSIZE > 1) ? $clog2(GSIZE) : 1;
  localparam int CNT_W     = $clog2(GSIZE + 1);
  localparam int PROBE_MAX = probe_bound(NGROUPS);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_PROBE} state_t;

  state_t           st;
  logic             op_full;
  logic [IDX_W-1:0] init_pos;
  logic [MEM_W-1:0] member;

  // Named internal events
  logic             accept_init, accept_full, accept_est;
  logic             probe_read, probe_last, init_last;
  logic             search_step;
  logic [RES_W-1:0] probe_grp;
  logic             verdict_decayed;
  logic [CNT_W-1:0] zeros_so_far;
  logic [RES_W-1:0] mid;
  logic             search_fin;
  logic [RES_W-1:0] search_res;

  assign accept_init = (st == S_IDLE) && start_init;
  assign accept_full = (st == S_IDLE) && !start_init && start_full;
  assign accept_est  = (st == S_IDLE) && !start_init && !start_full && start_est;

  assign probe_read  = (st == S_PROBE);
  assign probe_last  = probe_read && (int'(member) == GSIZE - 1);
  assign init_last   = (st == S_INIT) && (int'(init_pos) == LEN - 1);
  assign search_step = probe_last && !op_full;

  assign probe_grp = op_full ? RES_W'(NGROUPS - 1) : mid;
  assign tbl_idx   = (st == S_INIT) ? init_pos
                   : IDX_W'(order_pos(int'(probe_grp), int'(member), GSIZE));
  assign cell_addr = tbl_cell;
  assign cell_set  = (st == S_INIT);
  assign busy      = (st != S_IDLE);

  decay_vote_acc #(.GSIZE(GSIZE)) u_vote (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_en       (probe_read),
    .sample_last     (probe_last),
    .cell_zero       (!cell_rdata),
    .zeros_so_far    (zeros_so_far),
    .verdict_decayed (verdict_decayed)
  );

  decay_bsearch #(.NGROUPS(NGROUPS)) u_search (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept_est),
    .step         (search_step),
    .step_decayed (verdict_decayed),
    .mid          (mid),
    .fin_next     (search_fin),
    .res_next     (search_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      op_full      <= 1'b0;
      init_pos     <= '0;
      member       <= '0;
      done         <= 1'b0;
      full_decayed <= 1'b0;
      est_groups   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept_init) begin
            st       <= S_INIT;
            init_pos <= '0;
          end else if (accept_full || accept_est) begin
            st      <= S_PROBE;
            op_full <= accept_full;
            member  <= '0;
          end
        end
        S_INIT: begin
          init_pos <= init_pos + IDX_W'(1);
          if (init_last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_PROBE: begin
          if (probe_last) begin
            member <= '0;
            if (op_full) begin
              full_decayed <= verdict_decayed;
              done         <= 1'b1;
              st           <= S_IDLE;
            end else if (search_fin) begin
              est_groups <= search_res;
              done       <= 1'b1;
              st         <= S_IDLE;
            end
          end else begin
            member <= member + MEM_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Probe counter for the search-length bound
  logic [7:0] probes_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           probes_done <= '0;
    else if (accept_est)  probes_done <= '0;
    else if (search_step) probes_done <= probes_done + 8'd1;
  end

  // R5: no estimate takes more probes than the logarithmic bound
  assert_probe_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    search_step |-> (int'(probes_done) < PROBE_MAX));

  // R6: the full check never presents an order position before the last group
  assert_full_last_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_read && op_full) |-> (int'(tbl_idx) >= LEN - GSIZE));

  // R9: done lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the estimate output moves only on a completed estimate
  assert_est_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_step && search_fin) |=> $stable(est_groups));

  // R10: memory writes only occur inside a busy operation
  assert_set_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cell_set |-> busy);

  // R8: once running, a new start never returns the block to idle early
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !init_last && !probe_last) |=> busy);

endmodule

// File: tb/sim_decay_clock_est.sv
`timescale 1ns/1ps
module sim_decay_clock_est;
  localparam int NG  = 16;
  localparam int GS  = 4;
  localparam int AW  = 8;
  localparam int LEN = NG * GS;
  localparam int IW  = $clog2(LEN);
  localparam int RW  = $clog2(NG + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_init = 1'b0, start_full = 1'b0, start_est = 1'b0;
  logic [IW-1:0] tbl_idx;
  logic [AW-1:0] tbl_cell, cell_addr;
  logic cell_set, cell_rdata, busy, done, full_decayed;
  logic [RW-1:0] est_groups;

  always #4 clk = ~clk;

  logic mem [0:(1<<AW)-1];
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic tb_val = 1'b0;
  int set_cnt = 0, bad_set = 0, low_rd = 0;

  function automatic logic [AW-1:0] cell_of(input int p);
    return AW'((p * 37 + 11) % (1 << AW));
  endfunction
  function automatic bit tracked(input logic [AW-1:0] a);
    for (int p = 0; p < LEN; p++) if (cell_of(p) == a) return 1'b1;
    return 1'b0;
  endfunction

  assign tbl_cell   = cell_of(int'(tbl_idx));
  assign cell_rdata = mem[cell_addr];

  always @(posedge clk) begin
    if (cell_set) begin
      mem[cell_addr] <= 1'b1;
      set_cnt <= set_cnt + 1;
      if (!tracked(cell_addr)) bad_set <= bad_set + 1;
    end else if (tb_we) begin
      mem[tb_addr] <= tb_val;
    end
    if (busy && !cell_set && int'(tbl_idx) < LEN - GS) low_rd <= low_rd + 1;
  end

  decay_clock_est #(.NGROUPS(NG), .GSIZE(GS), .CELL_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_full(start_full),
    .start_est(start_est), .tbl_idx(tbl_idx), .tbl_cell(tbl_cell),
    .cell_addr(cell_addr), .cell_set(cell_set), .cell_rdata(cell_rdata),
    .busy(busy), .done(done), .full_decayed(full_decayed), .est_groups(est_groups));

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int zc [NG];
  int rot [NG];
  int lat;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected estimate: first group whose zeros are not a strict majority (R3/R4)
  function automatic int exp_est();
    for (int g = 0; g < NG; g++) if (zc[g] * 2 <= GS) return g;
    return NG;
  endfunction

  task automatic load_pattern();
    for (int p = 0; p < LEN; p++) begin
      @(negedge clk);
      tb_we   = 1'b1;
      tb_addr = cell_of(p);
      tb_val  = !(((p % GS) + rot[p / GS]) % GS < zc[p / GS]);
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_op(input bit i, input bit f, input bit e, input bit interfere);
    @(negedge clk);
    start_init = i; start_full = f; start_est = e;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_init = 1'b0; start_full = 1'b0; start_est = 1'b0;
      if (interfere && lat == 2) begin start_init = 1'b1; start_full = 1'b1; end
      if (done || lat > 300) break;
    end
    @(negedge clk);
    check(!done, "R9 done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, s1, unt, e_hold, exp;
    bit allone;
    void'($urandom(32'd2024));
    for (int a = 0; a < (1 << AW); a++) mem[a] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !cell_set && !full_decayed, "R1 reset flags", int'(busy), 0);
    check(est_groups == 0, "R1 reset est", int'(est_groups), 0);
    rst_n = 1'b1;

    // R2 init
    unt = 0;
    while (tracked(AW'(unt))) unt++;
    for (int g = 0; g < NG; g++) begin zc[g] = GS; rot[g] = 0; end
    load_pattern();
    s0 = set_cnt; s1 = bad_set;
    run_op(1, 0, 0, 0);
    check(lat == LEN + 1, "R2 init latency", lat, LEN + 1);
    check(set_cnt - s0 == LEN, "R2 write count", set_cnt - s0, LEN);
    check(bad_set == s1, "R2 untracked writes", bad_set - s1, 0);
    allone = 1'b1;
    for (int p = 0; p < LEN; p++) if (mem[cell_of(p)] !== 1'b1) allone = 1'b0;
    check(allone, "R2 all tracked set", int'(allone), 1);
    check(mem[unt] == 1'b0, "R2 untracked cell kept", int'(mem[unt]), 0);

    // R4 nothing decayed
    run_op(0, 0, 1, 0);
    check(est_groups == 0, "R4 none decayed", int'(est_groups), 0);
    check(lat <= 1 + GS * RW && (lat - 1) % GS == 0, "R5 latency none", lat, 1 + GS * RW);

    // R4/R6 all decayed
    for (int g = 0; g < NG; g++) zc[g] = GS;
    load_pattern();
    run_op(0, 0, 1, 0);
    check(est_groups == NG, "R4 all decayed", int'(est_groups), NG);
    e_hold = int'(est_groups);
    s0 = low_rd;
    run_op(0, 1, 0, 0);
    check(lat == GS + 1, "R6 full latency", lat, GS + 1);
    check(full_decayed == 1'b1, "R6 full verdict", int'(full_decayed), 1);
    check(low_rd == s0, "R6 only last group read", low_rd - s0, 0);
    check(int'(est_groups) == e_hold, "R9 est held over full", int'(est_groups), e_hold);

    // R3 tie at group 6 and in the last group
    for (int g = 0; g < NG; g++) begin zc[g] = (g < 6) ? 3 : (g == 6 ? 2 : 0); rot[g] = g % GS; end
    zc[NG-1] = 2;
    load_pattern();
    run_op(0, 0, 1, 0);
    check(est_groups == 6, "R3 tie holds in search", int'(est_groups), 6);
    run_op(0, 1, 0, 0);
    check(full_decayed == 1'b0, "R3 tie holds in full check", int'(full_decayed), 0);

    // R7 priority: full over estimate
    for (int g = 0; g < NG; g++) zc[g] = (g < 9) ? 3 : 1;
    zc[NG-1] = 1;
    load_pattern();
    run_op(0, 1, 1, 0);
    check(lat == GS + 1, "R7 full beats estimate", lat, GS + 1);
    check(est_groups == 6, "R7 estimate not run", int'(est_groups), 6);

    // R8 starts during an estimate are ignored
    s0 = set_cnt;
    run_op(0, 0, 1, 1);
    check(set_cnt == s0, "R8 no writes while busy", set_cnt - s0, 0);
    check(est_groups == 9, "R8 result unchanged", int'(est_groups), 9);
    check(lat <= 1 + GS * RW, "R8 latency", lat, 1 + GS * RW);

    // R7 priority: init over estimate (also R10 writes only then)
    s0 = set_cnt;
    run_op(1, 0, 1, 0);
    check(lat == LEN + 1, "R7 init beats estimate", lat, LEN + 1);
    check(set_cnt - s0 == LEN, "R10 writes only in init", set_cnt - s0, LEN);

    // Random ordered patterns with minority noise
    for (int it = 0; it < 24; it++) begin
      int b;
      b = $urandom_range(0, NG);
      for (int g = 0; g < NG; g++) begin
        zc[g]  = (g < b) ? $urandom_range(3, GS) : $urandom_range(0, 2);
        rot[g] = $urandom_range(0, GS - 1);
      end
      load_pattern();
      exp = exp_est();
      run_op(0, 0, 1, 0);
      check(int'(est_groups) == exp, "R4 random estimate", int'(est_groups), exp);
      check(lat <= 1 + GS * RW && (lat - 1) % GS == 0, "R5 random latency", lat, 1 + GS * RW);
      run_op(0, 1, 0, 0);
      check(full_decayed == (zc[NG-1] * 2 > GS), "R6 random full", int'(full_decayed),
            int'(zc[NG-1] * 2 > GS));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule